// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the message-passing interrupts for a memory with two independent ports, called left and right. The two highest word addresses are reserved as mailboxes. The all-ones address belongs to the right port, and the address one below it belongs to the left port. When a port writes the mailbox of the opposite port, it posts an interrupt to that port. When the owner reads its own mailbox, it acknowledges the interrupt and clears it. The message itself lives in the memory array, which is outside this block.

The block watches each port's enable, write strobe and word address. It also takes one busy input per port from the arbitration logic. While a port's busy input is active, that port can neither post an interrupt to its peer nor acknowledge its own. Each port gets one registered, active-low interrupt output. The address width is a parameter, and both mailbox addresses are derived from it.

Top module: `dp_mbox_irq`

## Requirements
- R1: After reset both interrupt outputs are high (inactive).
- R2: An enabled, non-busy left write (wr=1) to the all-ones address drives the right interrupt low on the following clock edge.
- R3: An enabled, non-busy right write to the all-ones-minus-one address drives the left interrupt low on the following clock edge.
- R4: An enabled, non-busy read (wr=0) by a port of its own mailbox returns that port's interrupt high on the following clock edge. The right port's mailbox is all-ones and the left port's is all-ones-minus-one.
- R5: A port reading the opposite port's mailbox leaves both interrupts unchanged.
- R6: While a port's busy input is high, its write to the peer's mailbox does not set the peer's interrupt. The busy input of the peer does not block the set.
- R7: While a port's busy input is high, its read of its own mailbox does not clear its interrupt.
- R8: If a set and a clear of the same interrupt occur in the same cycle, the interrupt ends up active (low).
- R9: Accesses with enable low, accesses to any non-mailbox address, and a port's writes to its own mailbox change neither interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_en_i | input | 1 | Left port access enable, active high |
| l_wr_i | input | 1 | Left port direction, 1 = write, 0 = read |
| l_addr_i | input | AW | Left port word address |
| l_busy_i | input | 1 | Left port busy, active high |
| r_en_i | input | 1 | Right port access enable, active high |
| r_wr_i | input | 1 | Right port direction, 1 = write, 0 = read |
| r_addr_i | input | AW | Right port word address |
| r_busy_i | input | 1 | Right port busy, active high |
| l_irq_no | output | 1 | Left port interrupt, active low, registered |
| r_irq_no | output | 1 | Right port interrupt, active low, registered |

## Verification
The only state in the block is the two interrupt flags, and each flag drives its output pin directly. A bad decode or a wrong flag update therefore appears on a pin one clock edge after the access that caused it. Each scenario checks both pins in that cycle. A mistake that changes the wrong port's flag, clears where it should set, or ignores busy shows up right away as a mismatch on one of the two outputs. The bench also holds the flags set across later harmless accesses, so that a clear or set that should not happen is caught as well.

// File: rtl/dp_mbox_pkg.sv
`timescale 1ns/1ps
package dp_mbox_pkg;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum int unsigned {
    PORT_L = 0,
    PORT_R = 1
  } port_e;

  // index of the opposite port
  function automatic int unsigned peer_of(input int unsigned p);
    return (p == PORT_L) ? PORT_R : PORT_L;
  endfunction
endpackage

// File: rtl/dp_mbox_decode.sv
`timescale 1ns/1ps
module dp_mbox_decode #(
  parameter int unsigned AW = 15,
  parameter logic [AW-1:0] OWN_ADDR = '1,
  parameter logic [AW-1:0] PEER_ADDR = '1
) (
  input  logic          en_i,
  input  logic          wr_i,
  input  logic          busy_i,
  input  logic [AW-1:0] addr_i,
  output logic          post_o,
  output logic          ack_o
);
  logic go;

  assign go     = en_i & ~busy_i;
  assign post_o = go &  wr_i & (addr_i == PEER_ADDR);
  assign ack_o  = go & ~wr_i & (addr_i == OWN_ADDR);
endmodule

// File: rtl/dp_mbox_flag.sv
`timescale 1ns/1ps
module dp_mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;  // set dominates
    else if (clr_i) pend_q <= 1'b0;
  end

  assign irq_no = ~pend_q;
endmodule

// File: rtl/dp_mbox_irq.sv
`timescale 1ns/1ps
module dp_mbox_irq #(
  parameter int unsigned AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_en_i,
  input  logic          l_wr_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          l_busy_i,
  input  logic          r_en_i,
  input  logic          r_wr_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic          r_busy_i,
  output logic          l_irq_no,
  output logic          r_irq_no
);
  import dp_mbox_pkg::*;

  localparam logic [AW-1:0] MBOX_R = {AW{1'b1}};
  localparam logic [AW-1:0] MBOX_L = MBOX_R - 1'b1;

  logic [NUM_PORTS-1:0]         en, wr, busy, post, ack, irq_n;
  logic [NUM_PORTS-1:0][AW-1:0] addr;

  assign en   = {r_en_i,   l_en_i};
  assign wr   = {r_wr_i,   l_wr_i};
  assign busy = {r_busy_i, l_busy_i};
  assign addr = {r_addr_i, l_addr_i};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [AW-1:0] OWN  = (p == PORT_R) ? MBOX_R : MBOX_L;
    localparam logic [AW-1:0] PEER = (p == PORT_R) ? MBOX_L : MBOX_R;

    dp_mbox_decode #(
      .AW       (AW),
      .OWN_ADDR (OWN),
      .PEER_ADDR(PEER)
    ) i_dec (
      .en_i  (en[p]),
      .wr_i  (wr[p]),
      .busy_i(busy[p]),
      .addr_i(addr[p]),
      .post_o(post[p]),
      .ack_o (ack[p])
    );

    dp_mbox_flag i_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (post[peer_of(p)]),
      .clr_i (ack[p]),
      .irq_no(irq_n[p])
    );
  end

  assign l_irq_no = irq_n[PORT_L];
  assign r_irq_no = irq_n[PORT_R];
endmodule

// File: rtl/dp_mbox_irq_chk.sv
`timescale 1ns/1ps
module dp_mbox_irq_chk #(
  parameter int unsigned AW = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          l_en_i,
  input logic          l_wr_i,
  input logic [AW-1:0] l_addr_i,
  input logic          l_busy_i,
  input logic          r_en_i,
  input logic          r_wr_i,
  input logic [AW-1:0] r_addr_i,
  input logic          r_busy_i,
  input logic          l_irq_no,
  input logic          r_irq_no
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};
  localparam logic [AW-1:0] NXT = TOP - 1'b1;

  logic l_posts, r_posts, l_acks, r_acks;
  assign l_posts = l_en_i & l_wr_i & ~l_busy_i & (l_addr_i == TOP);
  assign r_posts = r_en_i & r_wr_i & ~r_busy_i & (r_addr_i == NXT);
  assign l_acks  = l_en_i & ~l_wr_i & ~l_busy_i & (l_addr_i == NXT);
  assign r_acks  = r_en_i & ~r_wr_i & ~r_busy_i & (r_addr_i == TOP);

  assert_set_right_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_posts |=> !r_irq_no);
  assert_set_left_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_posts |=> !l_irq_no);
  assert_clear_right_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_acks && !l_posts) |=> r_irq_no);
  assert_clear_left_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_acks && !r_posts) |=> l_irq_no);
  assert_busy_blocks_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_irq_no && l_busy_i) |=> r_irq_no);
  assert_busy_blocks_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_irq_no && r_busy_i) |=> !r_irq_no);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_posts && r_acks) |=> !r_irq_no);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_en_i && !r_en_i) |=> ($stable(l_irq_no) && $stable(r_irq_no)));
endmodule

bind dp_mbox_irq dp_mbox_irq_chk #(.AW(AW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .l_en_i  (l_en_i),
  .l_wr_i  (l_wr_i),
  .l_addr_i(l_addr_i),
  .l_busy_i(l_busy_i),
  .r_en_i  (r_en_i),
  .r_wr_i  (r_wr_i),
  .r_addr_i(r_addr_i),
  .r_busy_i(r_busy_i),
  .l_irq_no(l_irq_no),
  .r_irq_no(r_irq_no)
);

// File: tb/test_dp_mbox_irq.sv
`timescale 1ns/1ps
module test_dp_mbox_irq;
  localparam int unsigned AW = 15;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};
  localparam logic [AW-1:0] NXT = TOP - 1'b1;
  localparam logic [AW-1:0] OTH = TOP - 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_wr = 0, l_busy = 0, r_en = 0, r_wr = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dp_mbox_irq #(.AW(AW)) i_dp_mbox_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .l_en_i(l_en), .l_wr_i(l_wr), .l_addr_i(l_addr), .l_busy_i(l_busy),
    .r_en_i(r_en), .r_wr_i(r_wr), .r_addr_i(r_addr), .r_busy_i(r_busy),
    .l_irq_no(l_irq_n), .r_irq_no(r_irq_n)
  );

  task automatic check(input string req, input logic exp_l, input logic exp_r);
    checks++;
    if (l_irq_n !== exp_l || r_irq_n !== exp_r) begin
      fails++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected l=%b r=%b",
               req, l_irq_n, r_irq_n, exp_l, exp_r);
    end
  endtask

  // one cycle of stimulus on both ports; returns at the next falling edge
  task automatic cyc(input logic le, input logic lw, input logic [AW-1:0] la, input logic lb,
                     input logic re, input logic rw, input logic [AW-1:0] ra, input logic rb);
    @(negedge clk);
    l_en = le; l_wr = lw; l_addr = la; l_busy = lb;
    r_en = re; r_wr = rw; r_addr = ra; r_busy = rb;
    @(negedge clk);
    l_en = 0; l_wr = 0; l_busy = 0; r_en = 0; r_wr = 0; r_busy = 0;
  endtask

  task automatic lacc(input logic w, input logic [AW-1:0] a, input logic b);
    cyc(1, w, a, b, 0, 0, '0, 0);
  endtask
  task automatic racc(input logic w, input logic [AW-1:0] a, input logic b);
    cyc(0, 0, '0, 0, 1, w, a, b);
  endtask

  task automatic t_reset;
    check("R1 reset", 1, 1);
  endtask

  task automatic t_post_ack;
    lacc(1, TOP, 0); check("R2 left posts right", 1, 0);
    racc(0, TOP, 0); check("R4 right acks", 1, 1);
    racc(1, NXT, 0); check("R3 right posts left", 0, 1);
    lacc(0, NXT, 0); check("R4 left acks", 1, 1);
  endtask

  task automatic t_peek;
    cyc(1, 1, TOP, 0, 1, 1, NXT, 0); check("R2 R3 both posted", 0, 0);
    lacc(0, TOP, 0); check("R5 left peeks right box", 0, 0);
    racc(0, NXT, 0); check("R5 right peeks left box", 0, 0);
    cyc(1, 0, NXT, 0, 1, 0, TOP, 0); check("R4 both ack", 1, 1);
  endtask

  task automatic t_busy;
    lacc(1, TOP, 1); check("R6 busy left blocks post", 1, 1);
    racc(1, NXT, 1); check("R6 busy right blocks post", 1, 1);
    cyc(1, 1, TOP, 0, 0, 0, '0, 1); check("R6 peer busy does not block", 1, 0);
    racc(0, TOP, 1); check("R7 busy right blocks ack", 1, 0);
    racc(0, TOP, 0); check("R4 ack after busy drops", 1, 1);
    racc(1, NXT, 0);
    lacc(0, NXT, 1); check("R7 busy left blocks ack", 0, 1);
    lacc(0, NXT, 0); check("R4 left ack", 1, 1);
  endtask

  task automatic t_collide;
    cyc(1, 1, TOP, 0, 1, 0, TOP, 0); check("R8 set beats clear right", 1, 0);
    cyc(1, 0, NXT, 0, 1, 1, NXT, 0); check("R8 set beats clear left", 0, 0);
    cyc(1, 1, TOP, 0, 1, 0, TOP, 0); check("R8 set beats clear while set", 0, 0);
    cyc(1, 0, NXT, 0, 1, 0, TOP, 0); check("R4 clear both", 1, 1);
  endtask

  task automatic t_ignore;
    cyc(0, 1, TOP, 0, 0, 1, NXT, 0); check("R9 disabled writes", 1, 1);
    cyc(1, 1, OTH, 0, 1, 1, OTH, 0); check("R9 other address writes", 1, 1);
    cyc(1, 1, NXT, 0, 1, 1, TOP, 0); check("R9 own mailbox writes", 1, 1);
    cyc(1, 1, TOP, 0, 1, 1, NXT, 0);
    cyc(0, 0, NXT, 0, 0, 0, TOP, 0); check("R9 disabled reads keep flags", 0, 0);
    cyc(1, 0, OTH, 0, 1, 0, '0, 0); check("R9 other address reads keep flags", 0, 0);
    cyc(1, 0, NXT, 0, 1, 0, TOP, 0); check("R4 final clear", 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_post_ack();
    t_peek();
    t_busy();
    t_collide();
    t_ignore();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule